// File: doc/BRIEF.md
# Inbound Message-Signalled Interrupt Capture Unit

This block watches a simplified stream of inbound memory writes and picks out the ones aimed at a programmable 64-bit doorbell address. Each such write is treated as a message-signalled interrupt. The low five bits of its 16-bit data select one of 32 vectors, and that vector's sticky status bit is set. The full data word is kept as the most recently received payload. Writes to any other address are not captured. They are handed on, one cycle later, through a pass-through output.

Software sees the block through a 32-bit register port. There it programs the two halves of the doorbell address, reads and clears the status bits, sets a per-vector mask, and reads the payload and a sticky activity flag. Two outputs go to the next-level interrupt aggregator:

- A level pending signal, high while any unmasked status bit is set.
- The activity flag, which goes high on any capture and stays high until software clears it after servicing.

Capture only happens while the external enable input is high.

Top module: `msi_vector_capture`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0xFFFFFFFF (all vectors masked), payload, activity and both doorbell halves read 0, and `msi_pending`, `msi_activity` and `pass_valid` are low.
- R2: A captured write is one where `in_wr_valid` is high, `capture_en` is high and `in_wr_addr` equals {doorbell-high, doorbell-low}. It sets status bit `in_wr_data[4:0]` on that clock edge, and no other status bit changes.
- R3: Each captured write stores `in_wr_data`, zero-extended, in the payload register (byte offset 0x10). The payload register holds that value until the next captured write.
- R4: An inbound write whose address differs from the doorbell changes no status, payload or activity state. It appears on `pass_valid`/`pass_addr`/`pass_data` one cycle later. A write whose address matches is never forwarded.
- R5: While `capture_en` is low, a matching write sets no status bit and changes neither payload nor activity.
- R6: Writing the status register (byte offset 0x08) clears each status bit whose written bit is 1 and leaves the bits written as 0 unchanged.
- R7: If a capture and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: `msi_pending` is registered and equals the OR over all vectors of (status AND NOT mask). It reflects a status or mask change on the same clock edge that updates those registers.
- R9: The mask register (byte offset 0x0C, bit n masks vector n) blocks only the pending output. A masked vector's status bit is still set on capture and still reads back.
- R10: The activity flag (bit 0 at byte offset 0x14, also driven on `msi_activity`) is set by every capture and is cleared by writing 1 to bit 0. A capture in the same cycle as that clear leaves it set.
- R11: The doorbell halves (low at 0x00, high at 0x04) read back as written. Register reads return data in `reg_rdata` on the edge after `reg_rd_en`. Unmapped or misaligned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Global enable for message capture |
| in_wr_valid | input | 1 | Inbound write present this cycle |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data | input | 16 | Inbound write data (message data) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pass_valid | output | 1 | Forwarded non-matching write valid |
| pass_addr | output | 64 | Forwarded write address |
| pass_data | output | 16 | Forwarded write data |
| msi_pending | output | 1 | OR of unmasked status bits |
| msi_activity | output | 1 | Sticky flag set by any capture |

## Verification
Every one of the 32 vectors is captured in turn with distinct data words. The accumulating status value therefore shows whether the index decode hits the right bit, and the payload readback shows whether the right word is stored. A second sweep takes each vector under a full mask and then unmasks it alone. This separates status recording from pending generation. All 64 single-bit corruptions of the doorbell address are sent to show that the compare covers both halves and that mismatches are forwarded intact. Same-cycle capture and clear are tried on the same bit and on different bits, which tells set-priority apart from clear-priority and from a clear that leaks into other bits.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  // Word indices of the register map (byte offset = index * 4)
  localparam int unsigned IDX_DB_LO   = 0;
  localparam int unsigned IDX_DB_HI   = 1;
  localparam int unsigned IDX_STATUS  = 2;
  localparam int unsigned IDX_MASK    = 3;
  localparam int unsigned IDX_PAYLOAD = 4;
  localparam int unsigned IDX_ACT     = 5;

  typedef struct packed {
    logic db_lo;
    logic db_hi;
    logic status;
    logic mask;
    logic act;
  } reg_sel_t;
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
  parameter int DB_W    = 64,
  parameter int DATA_W  = 16,
  parameter int NUM_VEC = 32
) (
  input  logic               in_valid,
  input  logic [DB_W-1:0]    in_addr,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [DB_W-1:0]    doorbell,
  input  logic               capture_en,
  output logic               hit,
  output logic               miss,
  output logic [NUM_VEC-1:0] set_vec
);
  localparam int VIDX_W = $clog2(NUM_VEC);

  logic addr_eq;
  logic [VIDX_W-1:0] vidx;

  assign addr_eq = (in_addr == doorbell);
  assign hit     = in_valid && addr_eq && capture_en;
  assign miss    = in_valid && !addr_eq;
  assign vidx    = in_data[VIDX_W-1:0];

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
    assign set_vec[i] = hit && (vidx == VIDX_W'(i));
  end
endmodule

// File: rtl/msi_status_bank.sv
module msi_status_bank #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] set_vec,
  input  logic               clr_wr,
  input  logic               mask_wr,
  input  logic [NUM_VEC-1:0] wbits,
  output logic [NUM_VEC-1:0] status_q,
  output logic [NUM_VEC-1:0] mask_q,
  output logic               pending_q
);
  logic [NUM_VEC-1:0] status_nxt;
  logic [NUM_VEC-1:0] mask_nxt;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
    // capture has priority over a same-cycle clear
    assign status_nxt[i] = set_vec[i] | (status_q[i] & ~(clr_wr & wbits[i]));
  end

  assign mask_nxt = mask_wr ? wbits : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      mask_q    <= '1;
      pending_q <= 1'b0;
    end else begin
      status_q  <= status_nxt;
      mask_q    <= mask_nxt;
      pending_q <= |(status_nxt & ~mask_nxt);
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((status_q & $past(wbits) & ~$past(set_vec)) == '0));

  assert_pending_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    pending_q == (|(status_q & ~mask_q)));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/msi_reg_if.sv
module msi_reg_if
  import msi_cap_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_W   = 32,
  parameter int DATA_W  = 16,
  parameter int NUM_VEC = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic                hit,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [NUM_VEC-1:0]  status_q,
  input  logic [NUM_VEC-1:0]  mask_q,
  output logic [2*REG_W-1:0]  doorbell,
  output logic                clr_wr,
  output logic                mask_wr,
  output logic                act_q,
  output logic [REG_W-1:0]    reg_rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  reg_sel_t          wsel;
  logic [REG_W-1:0]  db_lo_q, db_hi_q;
  logic [DATA_W-1:0] payload_q;
  logic [REG_W-1:0]  rd_mux;

  assign word    = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  assign wsel.db_lo  = reg_wr_en && aligned && (word == WORD_W'(IDX_DB_LO));
  assign wsel.db_hi  = reg_wr_en && aligned && (word == WORD_W'(IDX_DB_HI));
  assign wsel.status = reg_wr_en && aligned && (word == WORD_W'(IDX_STATUS));
  assign wsel.mask   = reg_wr_en && aligned && (word == WORD_W'(IDX_MASK));
  assign wsel.act    = reg_wr_en && aligned && (word == WORD_W'(IDX_ACT));

  assign clr_wr   = wsel.status;
  assign mask_wr  = wsel.mask;
  assign doorbell = {db_hi_q, db_lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      db_lo_q   <= '0;
      db_hi_q   <= '0;
      payload_q <= '0;
      act_q     <= 1'b0;
    end else begin
      if (wsel.db_lo) db_lo_q <= reg_wdata;
      if (wsel.db_hi) db_hi_q <= reg_wdata;
      if (hit) payload_q <= in_data;
      act_q <= hit | (act_q & ~(wsel.act & reg_wdata[0]));
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (word == WORD_W'(IDX_DB_LO))   rd_mux = db_lo_q;
      if (word == WORD_W'(IDX_DB_HI))   rd_mux = db_hi_q;
      if (word == WORD_W'(IDX_STATUS))  rd_mux = REG_W'(status_q);
      if (word == WORD_W'(IDX_MASK))    rd_mux = REG_W'(mask_q);
      if (word == WORD_W'(IDX_PAYLOAD)) rd_mux = REG_W'(payload_q);
      if (word == WORD_W'(IDX_ACT))     rd_mux = REG_W'(act_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

  assert_payload_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(payload_q));

  assert_act_set_R10: assert property (@(posedge clk) disable iff (rst)
    hit |=> act_q);
endmodule

// File: rtl/msi_vector_capture.sv
module msi_vector_capture #(
  parameter int ADDR_W  = 8,
  parameter int REG_W   = 32,
  parameter int DATA_W  = 16,
  parameter int NUM_VEC = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture_en,
  input  logic                 in_wr_valid,
  input  logic [2*REG_W-1:0]   in_wr_addr,
  input  logic [DATA_W-1:0]    in_wr_data,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 pass_valid,
  output logic [2*REG_W-1:0]   pass_addr,
  output logic [DATA_W-1:0]    pass_data,
  output logic                 msi_pending,
  output logic                 msi_activity
);
  localparam int DB_W   = 2 * REG_W;
  localparam int VIDX_W = $clog2(NUM_VEC);

  logic               hit, miss, clr_wr, mask_wr;
  logic [NUM_VEC-1:0] set_vec, status_q, mask_q;
  logic [DB_W-1:0]    doorbell;
  logic [VIDX_W-1:0]  vidx;

  assign vidx = in_wr_data[VIDX_W-1:0];

  msi_addr_match #(.DB_W(DB_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_match (
    .in_valid(in_wr_valid), .in_addr(in_wr_addr), .in_data(in_wr_data),
    .doorbell(doorbell), .capture_en(capture_en),
    .hit(hit), .miss(miss), .set_vec(set_vec));

  msi_status_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_wr(clr_wr),
    .mask_wr(mask_wr), .wbits(reg_wdata[NUM_VEC-1:0]),
    .status_q(status_q), .mask_q(mask_q), .pending_q(msi_pending));

  msi_reg_if #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W),
               .NUM_VEC(NUM_VEC)) u_regs (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hit(hit),
    .in_data(in_wr_data), .status_q(status_q), .mask_q(mask_q),
    .doorbell(doorbell), .clr_wr(clr_wr), .mask_wr(mask_wr),
    .act_q(msi_activity), .reg_rdata(reg_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_valid <= 1'b0;
      pass_addr  <= '0;
      pass_data  <= '0;
    end else begin
      pass_valid <= miss;
      if (miss) begin
        pass_addr <= in_wr_addr;
        pass_data <= in_wr_data;
      end
    end
  end

  assert_capture_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (in_wr_valid && capture_en && in_wr_addr == doorbell) |=> status_q[$past(vidx)]);

  assert_no_forward_match_R4: assert property (@(posedge clk) disable iff (rst)
    (in_wr_valid && in_wr_addr == doorbell) |=> !pass_valid);

  assert_disabled_no_set_R5: assert property (@(posedge clk) disable iff (rst)
    !capture_en |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: tb/tb_msi_vector_capture.sv
module tb_msi_vector_capture;
  localparam logic [7:0] A_DBLO = 8'h00, A_DBHI = 8'h04, A_STAT = 8'h08,
                         A_MASK = 8'h0C, A_PAY = 8'h10, A_ACT = 8'h14;

  logic        clk = 1'b0, rst = 1'b1, capture_en = 1'b0;
  logic        in_wr_valid = 1'b0;
  logic [63:0] in_wr_addr = '0;
  logic [15:0] in_wr_data = '0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pass_valid, msi_pending, msi_activity;
  logic [63:0] pass_addr;
  logic [15:0] pass_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] rd;
  logic [31:0] exp_stat;
  logic [15:0] exp_pay;
  localparam logic [63:0] DB = 64'h0000_00F0_1357_9BDC;

  always #5 clk = ~clk;

  msi_vector_capture dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask

  task automatic inbound(input logic [63:0] a, input logic [15:0] d);
    @(negedge clk); in_wr_valid = 1'b1; in_wr_addr = a; in_wr_data = d;
    @(negedge clk); in_wr_valid = 1'b0;
  endtask

  task automatic collide(input logic [15:0] d, input logic [7:0] a, input logic [31:0] w);
    @(negedge clk);
    in_wr_valid = 1'b1; in_wr_addr = DB; in_wr_data = d;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = w;
    @(negedge clk); in_wr_valid = 1'b0; reg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    reg_read(A_STAT, rd); chk("R1 status", rd, 0);
    reg_read(A_MASK, rd); chk("R1 mask", rd, 32'hFFFF_FFFF);
    reg_read(A_PAY, rd);  chk("R1 payload", rd, 0);
    reg_read(A_ACT, rd);  chk("R1 activity", rd, 0);
    reg_read(A_DBLO, rd); chk("R1 dblo", rd, 0);
    chk("R1 pending", msi_pending, 0);
    chk("R1 pass_valid", pass_valid, 0);

    // R11 doorbell readback, unmapped and misaligned
    reg_write(A_DBLO, DB[31:0]);
    reg_write(A_DBHI, DB[63:32]);
    reg_read(A_DBLO, rd); chk("R11 dblo", rd, DB[31:0]);
    reg_read(A_DBHI, rd); chk("R11 dbhi", rd, DB[63:32]);
    reg_read(8'h1C, rd);  chk("R11 unmapped", rd, 0);
    reg_read(8'h09, rd);  chk("R11 misaligned", rd, 0);

    // R2/R3 sweep all vectors
    capture_en = 1'b1;
    reg_write(A_MASK, 32'h0);
    exp_stat = 0;
    for (int v = 0; v < 32; v++) begin
      logic [15:0] d;
      d = 16'(((v * 16'h0123 + 16'h4A00) & 16'hFFE0) | v);
      inbound(DB, d);
      exp_stat = exp_stat | (32'h1 << v);
      chk("R8 pending after capture", msi_pending, 1);
      chk("R4 matched not forwarded", pass_valid, 0);
      reg_read(A_PAY, rd);  chk("R3 payload", rd, {16'h0, d});
      reg_read(A_STAT, rd); chk("R2 status accum", rd, exp_stat);
    end
    chk("R10 activity set", msi_activity, 1);

    // R6 W1C partial and full
    reg_write(A_STAT, 32'hAAAA_AAAA);
    reg_read(A_STAT, rd); chk("R6 partial clear", rd, 32'h5555_5555);
    chk("R8 pending partial", msi_pending, 1);
    reg_write(A_STAT, 32'h5555_5555);
    reg_read(A_STAT, rd); chk("R6 full clear", rd, 0);
    chk("R8 pending none", msi_pending, 0);
    reg_write(A_ACT, 32'h1);
    chk("R10 activity cleared", msi_activity, 0);

    // R8/R9 per-vector mask sweep
    reg_write(A_MASK, 32'hFFFF_FFFF);
    for (int v = 0; v < 32; v++) begin
      inbound(DB, 16'(v));
      chk("R9 masked no pending", msi_pending, 0);
      reg_read(A_STAT, rd); chk("R9 masked still recorded", rd, 32'h1 << v);
      reg_write(A_MASK, ~(32'h1 << v));
      chk("R8 unmasked pending", msi_pending, 1);
      reg_write(A_MASK, 32'hFFFF_FFFF);
      chk("R8 remasked", msi_pending, 0);
      reg_write(A_STAT, 32'h1 << v);
    end
    reg_write(A_MASK, 32'h0);
    reg_write(A_ACT, 32'h1);
    reg_read(A_PAY, rd); exp_pay = rd[15:0];

    // R4 single-bit address corruption sweep
    for (int k = 0; k < 64; k++) begin
      logic [63:0] a;
      a = DB ^ (64'h1 << k);
      inbound(a, 16'(k + 16'h0B00));
      chk("R4 pass_valid", pass_valid, 1);
      chk("R4 pass_addr", pass_addr, a);
      chk("R4 pass_data", pass_data, 64'(k + 16'h0B00));
      chk("R4 no pending", msi_pending, 0);
    end
    reg_read(A_STAT, rd); chk("R4 status untouched", rd, 0);
    reg_read(A_PAY, rd);  chk("R4 payload untouched", rd, {16'h0, exp_pay});
    chk("R4 activity untouched", msi_activity, 0);

    // R5 capture disabled
    capture_en = 1'b0;
    inbound(DB, 16'h7707);
    chk("R5 no pass", pass_valid, 0);
    reg_read(A_STAT, rd); chk("R5 status", rd, 0);
    reg_read(A_PAY, rd);  chk("R5 payload", rd, {16'h0, exp_pay});
    chk("R5 activity", msi_activity, 0);
    capture_en = 1'b1;

    // R7 collision on same bit, and on a different bit
    inbound(DB, 16'h0003);
    collide(16'h0003, A_STAT, 32'h8);
    reg_read(A_STAT, rd); chk("R7 same bit stays", rd, 32'h8);
    collide(16'h0005, A_STAT, 32'h8);
    reg_read(A_STAT, rd); chk("R7 other bit cleared", rd, 32'h20);
    // R10 collision with activity clear
    collide(16'h0005, A_ACT, 32'h1);
    chk("R10 set wins", msi_activity, 1);
    reg_read(A_ACT, rd); chk("R10 act reg", rd, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule